// File: doc/BRIEF.md
# Debug Run-Control and Abstract Command Engine

This block is the core of a debug module serving a single hart. An external debugger reaches it through a simple word-wide register port. Through that port it can raise a halt request, ask the hart to resume, drive a non-debug reset of the rest of the system, and launch abstract commands. The hart reports its progress by writing to fixed flag offsets on a second port: halted, going, exception and resuming. A four-state machine (Idle, Go, CmdExec, Resume) tracks that exchange, reports busy, and shows the hart what it is being asked to do.

Each illegal situation produces its own command-error code, and that code stays set until the debugger clears it. A module-active bit gates the whole block. While it is low, every other field holds its reset value. The block also holds a small set of argument words and program-buffer words that the hart uses while a command runs.

Top module: `rcc_top`

## Requirements
- R1: After reset the control register (address 0x10) reads 0 and the command status register (address 0x16) reads 0x0200_0002. That value has the program-buffer size in bits 28:24, busy at bit 12 clear, the error code in bits 10:8 clear, and the argument-word count in bits 3:0.
- R2: While the active bit (control bit 0) is 0, writes to every other field and register are ignored, and all of them read their reset values. Clearing the active bit returns the stored words to 0.
- R3: The hart-select field (control bits 25:16) is write-any-read-legal. A value above the highest implemented hart index is stored as that index, so writing all ones reads back 0 in the single-hart default.
- R4: Status bits 13 and 12 (all and any unavailable) follow the unavailable input.
- R5: The argument words at 0x04 onward and the program-buffer words at 0x20 onward read back what was written while no command is running.
- R6: A command write (address 0x17) while the hart is not halted or is unavailable sets the error code to 4 and starts nothing.
- R7: A command whose type field (bits 31:24) is nonzero sets the error code to 2 and starts nothing.
- R8: An accepted command moves the engine to Go: the go output rises and busy reads 1. After the going flag (hart offset 0x104) the go output drops and busy stays 1. Busy clears after the halted flag (offset 0x100).
- R9: While busy, a write to the command, command-status or auto-execute (0x18) register, or any access to an argument or program-buffer word, sets the error code to 1. Such a write changes no stored word.
- R10: A hart write to the exception flag (offset 0x108) during command execution ends the command with error code 3.
- R11: A nonzero error code is sticky. Only writing ones to bits 10:8 of the command status register clears it, and while it is nonzero new commands are ignored.
- R12: Control bit 31 drives the halt-request output directly. A halted flag write sets status bits 9 and 8 (all and any halted).
- R13: A control write with bit 30 set and bit 31 clear enters Resume: the resume output rises and busy reads 1. It also clears status bits 17 and 16. The resuming flag (offset 0x110) returns to Idle, sets bits 17 and 16, and clears the halted bits.
- R14: Control bit 1 drives the non-debug reset output, and asserting it leaves the stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dbg_valid_i | input | 1 | Debugger register access in this cycle |
| dbg_write_i | input | 1 | Access is a write |
| dbg_addr_i | input | 7 | Debugger register address |
| dbg_wdata_i | input | 32 | Write data |
| dbg_rdata_o | output | 32 | Read data, same cycle |
| hart_flag_we_i | input | 1 | Hart flag write strobe |
| hart_flag_addr_i | input | 12 | Hart flag offset |
| hart_unavail_i | input | 1 | Hart is unavailable (held in reset) |
| halt_req_o | output | 1 | Halt request to the hart |
| ndm_reset_o | output | 1 | Non-debug reset request |
| dm_active_o | output | 1 | Module-active bit |
| hart_go_o | output | 1 | Hart is asked to run the command |
| hart_resume_o | output | 1 | Hart is asked to resume |

## Verification
A wrong state in the engine shows at the ports within one cycle. The go and resume outputs and the busy bit follow the state register directly, so a missed or extra transition is visible on the next read. A wrong error code shows on the next command-status read, and it then stays wrong because the code is sticky. A gating fault shows as a halt or reset output that follows a write made while the module was inactive.

// File: rtl/rcc_pkg.sv
`timescale 1ns/1ps
package rcc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_GO, ST_EXEC, ST_RESUME} rcc_state_e;

  localparam logic [6:0] A_DATA0 = 7'h04;
  localparam logic [6:0] A_CTRL  = 7'h10;
  localparam logic [6:0] A_STAT  = 7'h11;
  localparam logic [6:0] A_ACS   = 7'h16;
  localparam logic [6:0] A_CMD   = 7'h17;
  localparam logic [6:0] A_AUTO  = 7'h18;
  localparam logic [6:0] A_PROG0 = 7'h20;

  localparam logic [11:0] F_HALTED   = 12'h100;
  localparam logic [11:0] F_GOING    = 12'h104;
  localparam logic [11:0] F_EXCEPT   = 12'h108;
  localparam logic [11:0] F_RESUMING = 12'h110;

  localparam logic [2:0] ERR_NONE  = 3'd0;
  localparam logic [2:0] ERR_BUSY  = 3'd1;
  localparam logic [2:0] ERR_UNSUP = 3'd2;
  localparam logic [2:0] ERR_EXC   = 3'd3;
  localparam logic [2:0] ERR_STATE = 3'd4;
endpackage

// File: rtl/rcc_store.sv
`timescale 1ns/1ps
module rcc_store #(
  parameter int WORDS = 2,
  parameter int W     = 32,
  localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      we_i,
  input  logic [IW-1:0]             idx_i,
  input  logic [W-1:0]              wdata_i,
  output logic [WORDS-1:0][W-1:0]   words_o
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [W-1:0] word_q, word_d;
    logic         word_en;
    assign word_en = clr_i | (we_i & (idx_i == IW'(g)));
    always_comb begin
      word_d = clr_i ? '0 : wdata_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      word_q <= '0;
      else if (word_en) word_q <= word_d;
    end
    assign words_o[g] = word_q;
  end
endmodule

// File: rtl/rcc_ctrl.sv
`timescale 1ns/1ps
module rcc_ctrl #(
  parameter int HART_MAX = 0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic        f_halted_i,
  input  logic        f_resuming_i,
  output logic        active_o,
  output logic        haltreq_o,
  output logic        ndm_o,
  output logic [9:0]  hartsel_o,
  output logic        resume_o,
  output logic        halted_o,
  output logic        rack_o
);
  localparam logic [9:0] HSEL_MAX = 10'(HART_MAX);

  logic       active_q, active_d;
  logic       halt_q, halt_d, ndm_q, ndm_d, hlt_q, hlt_d, rack_q, rack_d;
  logic [9:0] hsel_q, hsel_d;
  logic       upd;

  assign upd      = wr_i & active_q & wdata_i[0];
  assign resume_o = upd & wdata_i[30] & ~wdata_i[31];

  always_comb begin
    active_d = wr_i ? wdata_i[0] : active_q;
    halt_d = halt_q; ndm_d = ndm_q; hsel_d = hsel_q;
    hlt_d  = hlt_q;  rack_d = rack_q;
    if (!active_q) begin
      halt_d = 1'b0; ndm_d = 1'b0; hsel_d = '0; hlt_d = 1'b0; rack_d = 1'b0;
    end else begin
      if (upd) begin
        halt_d = wdata_i[31];
        ndm_d  = wdata_i[1];
        hsel_d = (wdata_i[25:16] > HSEL_MAX) ? HSEL_MAX : wdata_i[25:16];
      end
      if (resume_o)     rack_d = 1'b0;
      if (f_halted_i)   hlt_d  = 1'b1;
      if (f_resuming_i) begin
        hlt_d  = 1'b0;
        rack_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0; halt_q <= 1'b0; ndm_q <= 1'b0; hsel_q <= '0;
      hlt_q <= 1'b0; rack_q <= 1'b0;
    end else begin
      active_q <= active_d; halt_q <= halt_d; ndm_q <= ndm_d; hsel_q <= hsel_d;
      hlt_q <= hlt_d; rack_q <= rack_d;
    end
  end

  assign active_o  = active_q;
  assign haltreq_o = halt_q;
  assign ndm_o     = ndm_q;
  assign hartsel_o = hsel_q;
  assign halted_o  = hlt_q;
  assign rack_o    = rack_q;
endmodule

// File: rtl/rcc_fsm.sv
`timescale 1ns/1ps
module rcc_fsm
  import rcc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic       cmd_wr_i,
  input  logic [7:0] cmdtype_i,
  input  logic       acs_wr_i,
  input  logic [2:0] clr_mask_i,
  input  logic       viol_i,
  input  logic       resume_i,
  input  logic       halted_i,
  input  logic       unavail_i,
  input  logic       f_going_i,
  input  logic       f_halted_i,
  input  logic       f_except_i,
  input  logic       f_resuming_i,
  output rcc_state_e state_o,
  output logic [2:0] err_o
);
  rcc_state_e st_q, st_d;
  logic [2:0] err_q, err_d;

  always_comb begin
    st_d  = st_q;
    err_d = err_q;
    if (!active_i) begin
      st_d  = ST_IDLE;
      err_d = ERR_NONE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (resume_i) st_d = ST_RESUME;
          else if (cmd_wr_i && err_q == ERR_NONE) begin
            if (cmdtype_i != 8'd0)            err_d = ERR_UNSUP;
            else if (unavail_i || !halted_i)  err_d = ERR_STATE;
            else                              st_d  = ST_GO;
          end
          if (acs_wr_i) err_d = err_q & ~clr_mask_i;
        end
        ST_GO: begin
          if (f_halted_i)     st_d = ST_IDLE;
          else if (f_going_i) st_d = ST_EXEC;
        end
        ST_EXEC: begin
          if (f_except_i) begin
            st_d = ST_IDLE;
            if (err_q == ERR_NONE) err_d = ERR_EXC;
          end else if (f_halted_i) st_d = ST_IDLE;
        end
        ST_RESUME: begin
          if (f_resuming_i) st_d = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
      if (viol_i && err_q == ERR_NONE) err_d = ERR_BUSY;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      err_q <= ERR_NONE;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  assign state_o = st_q;
  assign err_o   = err_q;
endmodule

// File: rtl/rcc_top.sv
`timescale 1ns/1ps
module rcc_top
  import rcc_pkg::*;
#(
  parameter int DATA_WORDS = 2,
  parameter int PROG_WORDS = 2,
  parameter int HART_MAX   = 0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        dbg_valid_i,
  input  logic        dbg_write_i,
  input  logic [6:0]  dbg_addr_i,
  input  logic [31:0] dbg_wdata_i,
  output logic [31:0] dbg_rdata_o,
  input  logic        hart_flag_we_i,
  input  logic [11:0] hart_flag_addr_i,
  input  logic        hart_unavail_i,
  output logic        halt_req_o,
  output logic        ndm_reset_o,
  output logic        dm_active_o,
  output logic        hart_go_o,
  output logic        hart_resume_o
);
  localparam int DIW = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1;
  localparam int PIW = (PROG_WORDS > 1) ? $clog2(PROG_WORDS) : 1;

  logic wr, active, haltreq, ndm, resume, halted, rack, busy, viol;
  logic [9:0] hartsel;
  logic [6:0] data_off, prog_off;
  logic hit_data, hit_prog, hit_ctrl, hit_acs, hit_cmd, hit_auto;
  logic f_halted, f_going, f_except, f_resuming;
  logic [2:0] cmd_err;
  rcc_state_e state;
  logic [DATA_WORDS-1:0][31:0] data_w;
  logic [PROG_WORDS-1:0][31:0] prog_w;
  logic [0:0][31:0]            auto_w;

  assign wr       = dbg_valid_i & dbg_write_i;
  assign data_off = dbg_addr_i - A_DATA0;
  assign prog_off = dbg_addr_i - A_PROG0;
  assign hit_data = (dbg_addr_i >= A_DATA0) && (data_off < 7'(DATA_WORDS));
  assign hit_prog = (dbg_addr_i >= A_PROG0) && (prog_off < 7'(PROG_WORDS));
  assign hit_ctrl = dbg_addr_i == A_CTRL;
  assign hit_acs  = dbg_addr_i == A_ACS;
  assign hit_cmd  = dbg_addr_i == A_CMD;
  assign hit_auto = dbg_addr_i == A_AUTO;

  assign f_halted   = hart_flag_we_i & (hart_flag_addr_i == F_HALTED);
  assign f_going    = hart_flag_we_i & (hart_flag_addr_i == F_GOING);
  assign f_except   = hart_flag_we_i & (hart_flag_addr_i == F_EXCEPT);
  assign f_resuming = hart_flag_we_i & (hart_flag_addr_i == F_RESUMING);

  assign busy = state != ST_IDLE;
  assign viol = busy & ((wr & (hit_acs | hit_cmd | hit_auto)) |
                        (dbg_valid_i & (hit_data | hit_prog)));

  rcc_ctrl #(.HART_MAX(HART_MAX)) u_ctrl (
    .clk_i, .rst_ni, .wr_i(wr & hit_ctrl), .wdata_i(dbg_wdata_i),
    .f_halted_i(f_halted), .f_resuming_i(f_resuming),
    .active_o(active), .haltreq_o(haltreq), .ndm_o(ndm), .hartsel_o(hartsel),
    .resume_o(resume), .halted_o(halted), .rack_o(rack)
  );

  rcc_fsm u_fsm (
    .clk_i, .rst_ni, .active_i(active), .cmd_wr_i(wr & hit_cmd),
    .cmdtype_i(dbg_wdata_i[31:24]), .acs_wr_i(wr & hit_acs),
    .clr_mask_i(dbg_wdata_i[10:8]), .viol_i(viol), .resume_i(resume),
    .halted_i(halted), .unavail_i(hart_unavail_i), .f_going_i(f_going),
    .f_halted_i(f_halted), .f_except_i(f_except), .f_resuming_i(f_resuming),
    .state_o(state), .err_o(cmd_err)
  );

  rcc_store #(.WORDS(DATA_WORDS)) u_data (
    .clk_i, .rst_ni, .clr_i(~active), .we_i(wr & hit_data & ~busy & active),
    .idx_i(data_off[DIW-1:0]), .wdata_i(dbg_wdata_i), .words_o(data_w)
  );

  rcc_store #(.WORDS(PROG_WORDS)) u_prog (
    .clk_i, .rst_ni, .clr_i(~active), .we_i(wr & hit_prog & ~busy & active),
    .idx_i(prog_off[PIW-1:0]), .wdata_i(dbg_wdata_i), .words_o(prog_w)
  );

  rcc_store #(.WORDS(1)) u_auto (
    .clk_i, .rst_ni, .clr_i(~active), .we_i(wr & hit_auto & ~busy & active),
    .idx_i(1'b0), .wdata_i(dbg_wdata_i), .words_o(auto_w)
  );

  always_comb begin
    dbg_rdata_o = '0;
    if (hit_data)      dbg_rdata_o = data_w[data_off[DIW-1:0]];
    else if (hit_prog) dbg_rdata_o = prog_w[prog_off[PIW-1:0]];
    else if (hit_ctrl) dbg_rdata_o = {haltreq, 5'b0, hartsel, 14'b0, ndm, active};
    else if (hit_acs)  dbg_rdata_o = {3'b0, 5'(PROG_WORDS), 11'b0, busy, 1'b0,
                                      cmd_err, 4'b0, 4'(DATA_WORDS)};
    else if (hit_auto) dbg_rdata_o = auto_w[0];
    else if (dbg_addr_i == A_STAT)
      dbg_rdata_o = {14'b0, rack, rack, 2'b0, hart_unavail_i, hart_unavail_i,
                     2'b0, halted, halted, 8'b0};
  end

  assign halt_req_o    = haltreq;
  assign ndm_reset_o   = ndm;
  assign dm_active_o   = active;
  assign hart_go_o     = state == ST_GO;
  assign hart_resume_o = state == ST_RESUME;
endmodule

// File: rtl/rcc_top_chk.sv
`timescale 1ns/1ps
module rcc_top_chk
  import rcc_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        dbg_valid_i,
  input logic        dbg_write_i,
  input logic [6:0]  dbg_addr_i,
  input logic        hart_flag_we_i,
  input logic [11:0] hart_flag_addr_i,
  input logic        halt_req_o,
  input logic        ndm_reset_o,
  input logic        dm_active_o,
  input logic        hart_go_o,
  input logic        hart_resume_o,
  input logic [2:0]  cmd_err
);
  logic acs_wr, ctrl_wr, cmd_wr;
  assign acs_wr  = dbg_valid_i && dbg_write_i && dbg_addr_i == A_ACS;
  assign ctrl_wr = dbg_valid_i && dbg_write_i && dbg_addr_i == A_CTRL;
  assign cmd_wr  = dbg_valid_i && dbg_write_i && dbg_addr_i == A_CMD;

  assert_inactive_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dm_active_o |=> (!halt_req_o && !ndm_reset_o && !hart_go_o));

  assert_err_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_err != 3'd0 && !acs_wr && dm_active_o) |=> cmd_err == $past(cmd_err));

  assert_go_after_cmd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hart_go_o) |-> $past(cmd_wr));

  assert_resume_ack_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hart_resume_o && hart_flag_we_i && hart_flag_addr_i == F_RESUMING) |=> !hart_resume_o);

  assert_halt_held_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dm_active_o && !ctrl_wr) |=> $stable(halt_req_o));
endmodule

bind rcc_top rcc_top_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dbg_valid_i(dbg_valid_i),
  .dbg_write_i(dbg_write_i), .dbg_addr_i(dbg_addr_i),
  .hart_flag_we_i(hart_flag_we_i), .hart_flag_addr_i(hart_flag_addr_i),
  .halt_req_o(halt_req_o), .ndm_reset_o(ndm_reset_o), .dm_active_o(dm_active_o),
  .hart_go_o(hart_go_o), .hart_resume_o(hart_resume_o), .cmd_err(cmd_err)
);

// File: tb/rcc_top_tb.sv
`timescale 1ns/1ps
module rcc_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_valid = 1'b0, dbg_write = 1'b0;
  logic [6:0]  dbg_addr = '0;
  logic [31:0] dbg_wdata = '0, dbg_rdata;
  logic        flag_we = 1'b0;
  logic [11:0] flag_addr = '0;
  logic        unavail = 1'b0;
  logic        halt_req, ndm_rst, dm_active, hart_go, hart_resume;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] val; string tag; } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  rcc_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dbg_valid_i(dbg_valid), .dbg_write_i(dbg_write),
    .dbg_addr_i(dbg_addr), .dbg_wdata_i(dbg_wdata), .dbg_rdata_o(dbg_rdata),
    .hart_flag_we_i(flag_we), .hart_flag_addr_i(flag_addr), .hart_unavail_i(unavail),
    .halt_req_o(halt_req), .ndm_reset_o(ndm_rst), .dm_active_o(dm_active),
    .hart_go_o(hart_go), .hart_resume_o(hart_resume)
  );

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && dbg_valid && !dbg_write) begin
      checks++;
      if (sb_q.size() == 0) begin
        failures++;
        $display("FAIL unexpected read actual=%h expected=none", dbg_rdata);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (dbg_rdata !== e.val) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", e.tag, dbg_rdata, e.val);
        end
      end
    end
  end

  task automatic op(input logic w, input logic [6:0] a, input logic [31:0] d);
    dbg_valid = 1'b1; dbg_write = w; dbg_addr = a; dbg_wdata = d;
    @(posedge clk); #1;
    dbg_valid = 1'b0; dbg_write = 1'b0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    op(1'b1, a, d);
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] e, input string tag);
    exp_t x;
    x.val = e; x.tag = tag;
    sb_q.push_back(x);
    op(1'b0, a, 32'd0);
  endtask

  task automatic hflag(input logic [11:0] a);
    flag_we = 1'b1; flag_addr = a;
    @(posedge clk); #1;
    flag_we = 1'b0;
  endtask

  task automatic chk(input string tag, input logic act, input logic e);
    checks++;
    if (act !== e) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, e);
    end
  endtask

  localparam logic [31:0] ACS0 = 32'h0200_0002;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset values
    rd(7'h10, 32'h0, "R1 ctrl reset");
    rd(7'h16, ACS0, "R1 acs reset");
    chk("R1 halt_req reset", halt_req, 1'b0);
    // R2 writes ignored while inactive
    wr(7'h10, 32'h8000_0002);
    wr(7'h04, 32'h1234);
    rd(7'h10, 32'h0, "R2 ctrl while inactive");
    rd(7'h04, 32'h0, "R2 data while inactive");
    chk("R2 halt_req while inactive", halt_req, 1'b0);
    wr(7'h10, 32'h1);
    chk("R2 active out", dm_active, 1'b1);
    // R3 hartsel WARL
    wr(7'h10, 32'h03FF_0001);
    rd(7'h10, 32'h1, "R3 hartsel clamp");
    // R4 unavailable
    unavail = 1'b1;
    rd(7'h11, 32'h3000, "R4 unavail set");
    unavail = 1'b0;
    rd(7'h11, 32'h0, "R4 unavail clear");
    // R5 storage
    wr(7'h04, 32'hA5A5); wr(7'h05, 32'h5A5A); wr(7'h21, 32'hC0DE);
    rd(7'h04, 32'hA5A5, "R5 data0");
    rd(7'h05, 32'h5A5A, "R5 data1");
    rd(7'h21, 32'hC0DE, "R5 prog1");
    // R6 not halted
    wr(7'h17, 32'h0);
    chk("R6 no go", hart_go, 1'b0);
    rd(7'h16, ACS0 | 32'h400, "R6 err not halted");
    wr(7'h16, 32'h700);
    rd(7'h16, ACS0, "R11 err cleared");
    // R7 unsupported
    wr(7'h17, 32'h0100_0000);
    rd(7'h16, ACS0 | 32'h200, "R7 err unsupported");
    wr(7'h16, 32'h700);
    // R12 halt
    wr(7'h10, 32'h8000_0001);
    chk("R12 halt_req out", halt_req, 1'b1);
    hflag(12'h100);
    rd(7'h11, 32'h300, "R12 halted status");
    // R6 unavailable while halted
    unavail = 1'b1;
    wr(7'h17, 32'h0);
    rd(7'h16, ACS0 | 32'h400, "R6 err unavailable");
    unavail = 1'b0;
    wr(7'h16, 32'h700);
    // R11 sticky blocks new commands
    wr(7'h17, 32'h0200_0000);
    wr(7'h17, 32'h0);
    chk("R11 blocked cmd no go", hart_go, 1'b0);
    rd(7'h16, ACS0 | 32'h200, "R11 err sticky");
    wr(7'h16, 32'h700);
    // R8 + R10 go, going, exception
    wr(7'h17, 32'h0);
    chk("R8 go out", hart_go, 1'b1);
    rd(7'h16, ACS0 | 32'h1000, "R8 busy in go");
    hflag(12'h104);
    chk("R8 go drops after going", hart_go, 1'b0);
    rd(7'h16, ACS0 | 32'h1000, "R8 busy after going");
    hflag(12'h108);
    rd(7'h16, ACS0 | 32'h300, "R10 err exception");
    wr(7'h16, 32'h700);
    // R9 busy violations
    wr(7'h17, 32'h0);
    wr(7'h04, 32'hFFFF);
    wr(7'h16, 32'h700);
    rd(7'h16, ACS0 | 32'h1100, "R9 err busy kept");
    hflag(12'h104);
    hflag(12'h100);
    rd(7'h16, ACS0 | 32'h100, "R8 busy clears on halted");
    rd(7'h04, 32'hA5A5, "R9 data write ignored");
    wr(7'h16, 32'h700);
    // R13 resume
    wr(7'h10, 32'h4000_0001);
    chk("R13 halt_req dropped", halt_req, 1'b0);
    chk("R13 resume out", hart_resume, 1'b1);
    rd(7'h16, ACS0 | 32'h1000, "R13 busy in resume");
    hflag(12'h110);
    chk("R13 resume done", hart_resume, 1'b0);
    rd(7'h11, 32'h3_0000, "R13 resumeack set");
    wr(7'h10, 32'h4000_0001);
    rd(7'h11, 32'h0, "R13 resumeack cleared");
    hflag(12'h110);
    // R14 ndmreset
    wr(7'h10, 32'h3);
    chk("R14 ndm out", ndm_rst, 1'b1);
    rd(7'h04, 32'hA5A5, "R14 data kept");
    wr(7'h10, 32'h1);
    chk("R14 ndm released", ndm_rst, 1'b0);
    // R2 deactivate clears
    wr(7'h10, 32'h0);
    wr(7'h10, 32'h1);
    rd(7'h04, 32'h0, "R2 data cleared");
    rd(7'h16, ACS0, "R2 acs reset");
    repeat (2) @(posedge clk);
    if (sb_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL scoreboard R1 actual=%0d expected=0 pending", sb_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog all actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule